// File: doc/BRIEF.md
# Bidirectional Power-On Reset Pin Controller

This block controls an open-drain, active-low reset pin that both the chip and outside devices can pull low. It watches the pin for a falling edge and, when it sees one, sends a one-cycle start request to the reset sequencer. When the sequencer reports a power-on cause or a destructive event, the block pulls the pin low itself. It keeps pulling until the sequencer signals the end of phase 0.

The pin input is blanked from the moment the chip starts driving the pin. It stays blanked for a settling interval after the drive is released, which gives the pull-up time to bring the line back up. Without this blanking, the chip would see its own drive and restart the sequence.

A second handshake to the sequencer, exit-ready, holds the sequence at its final exit while the line is still held low from outside. When the self-test variant is selected, exit-ready also waits for the self-test completion strobe. The sequencer then applies this check after phase 3 instead of at the normal exit.

Top module: `prst_pin_ctrl`

## Requirements
- R1: The pin input passes through a SYNC_STAGES-flop synchronizer. When the synchronized value reads 1 on one clock and 0 on the next while detection is armed, `seq_start` is high for exactly one cycle. With two stages this cycle is the third clock edge after the low level is first sampled.
- R2: While the block is idle or settling, a high `por_evt` or `dest_evt` makes `pin_oe` go high on the next clock edge (1 means the pin is pulled low).
- R3: Once high, `pin_oe` stays high until `ph0_end` is sampled high. It then goes low on that same clock edge.
- R4: The synchronized input does not trigger `seq_start` while `pin_oe` is high or while the settling interval is running.
- R5: Edge detection and exit-ready are re-armed exactly SETTLE_CYC clock cycles after `pin_oe` goes low. A new trigger during settling restarts the drive.
- R6: `exit_ready` is high only when the block is armed and the synchronized pin reads 1. A line held low from outside therefore keeps it low, and it also produces no `seq_start` once the block is re-armed.
- R7: With SELF_TEST=1, `exit_ready` also needs a `st_done` strobe seen since the last accepted trigger or `seq_start`. A clear that falls in the same cycle as `st_done` wins.
- R8: After reset, `pin_oe` and `seq_start` are 0 and the block is armed. `exit_ready` is 1 with SELF_TEST=0 and 0 with SELF_TEST=1 while the pin is high.
- R9: Triggers that arrive while `pin_oe` is high are ignored. The drive still ends on the first `ph0_end`.
- R10: SETTLE_CYC equals FAST_CYCLES when SIM_FAST=1. Otherwise it equals (CLK_HZ/1e6)*SETTLE_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Level read back from the reset pin |
| pin_oe | output | 1 | 1 pulls the pin low (open drain) |
| por_evt | input | 1 | Power-on cause from the sequencer |
| dest_evt | input | 1 | Destructive-event cause from the sequencer |
| ph0_end | input | 1 | Sequencer has reached the end of phase 0 |
| st_done | input | 1 | Self-test completion strobe |
| exit_ready | output | 1 | Sequence may leave to application mode |
| seq_start | output | 1 | One-cycle request to start the reset sequence |

## Verification
The bench builds two copies with SIM_FAST=1 and FAST_CYCLES=20, one with SELF_TEST=1 and one with SELF_TEST=0. The short interval lets it measure the exact re-arm point and run many drive and settle rounds within the run. It also lets it start a new trigger partway through settling. Sharing the stimulus between the two copies shows how the self-test strobe gates exit-ready against the plain variant, cycle for cycle.

// File: rtl/prst_pkg.sv
package prst_pkg;

   typedef enum logic [1:0] {
      PST_IDLE   = 2'd0,
      PST_DRIVE  = 2'd1,
      PST_SETTLE = 2'd2
   } prst_state_e;

   function automatic int unsigned settle_cycles(input int unsigned clk_hz,
                                                 input int unsigned settle_us,
                                                 input bit          fast,
                                                 input int unsigned fast_cyc);
      if (fast) return fast_cyc;
      return (clk_hz / 1000000) * settle_us;
   endfunction

endpackage

// File: rtl/prst_sync.sv
module prst_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= RST_VAL;
            else        ff <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= {STAGES{RST_VAL}};
            else        ff <= {ff[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = ff[STAGES-1];
endmodule

// File: rtl/prst_fall_det.sv
module prst_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic smp,
   input  logic en,
   output logic pulse
);
   logic prev_q;
   logic fall;

   assign fall = en & prev_q & ~smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         pulse  <= 1'b0;
      end else begin
         prev_q <= smp;
         pulse  <= fall;
      end
   end
endmodule

// File: rtl/prst_settle_timer.sv
module prst_settle_timer #(
   parameter int unsigned LOAD_VAL = 16,
   localparam int CNT_W = $clog2(LOAD_VAL + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= CNT_W'(LOAD_VAL - 1);
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/prst_drive_fsm.sv
module prst_drive_fsm
   import prst_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic ph0_end,
   input  logic tmr_done,
   output logic oe,
   output logic armed,
   output logic accept,
   output logic tmr_load,
   output logic tmr_run
);
   prst_state_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      accept   = 1'b0;
      tmr_load = 1'b0;
      unique case (st_q)
         PST_IDLE: begin
            if (trig) begin
               st_d   = PST_DRIVE;
               accept = 1'b1;
            end
         end
         PST_DRIVE: begin
            if (ph0_end) begin
               st_d     = PST_SETTLE;
               tmr_load = 1'b1;
            end
         end
         PST_SETTLE: begin
            if (trig) begin
               st_d   = PST_DRIVE;
               accept = 1'b1;
            end else if (tmr_done) begin
               st_d = PST_IDLE;
            end
         end
         default: st_d = PST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PST_IDLE;
      else        st_q <= st_d;
   end

   assign oe      = (st_q == PST_DRIVE);
   assign armed   = (st_q == PST_IDLE);
   assign tmr_run = (st_q == PST_SETTLE);
endmodule

// File: rtl/prst_exit_gate.sv
module prst_exit_gate #(
   parameter bit SELF_TEST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic pin_hi,
   input  logic st_done,
   input  logic clr,
   output logic exit_ready
);
   logic st_ok;

   generate
      if (SELF_TEST) begin : g_selftest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       st_ok <= 1'b0;
            else if (clr)     st_ok <= 1'b0;
            else if (st_done) st_ok <= 1'b1;
         end
      end else begin : g_plain
         assign st_ok = 1'b1;
      end
   endgenerate

   assign exit_ready = armed & pin_hi & st_ok;
endmodule

// File: rtl/prst_pin_ctrl.sv
module prst_pin_ctrl
   import prst_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 200_000_000,
   parameter int unsigned SETTLE_US   = 4000,
   parameter bit          SIM_FAST    = 1'b0,
   parameter int unsigned FAST_CYCLES = 16,
   parameter int          SYNC_STAGES = 2,
   parameter bit          SELF_TEST   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic pin_oe,
   input  logic por_evt,
   input  logic dest_evt,
   input  logic ph0_end,
   input  logic st_done,
   output logic exit_ready,
   output logic seq_start
);
   localparam int unsigned SETTLE_CYC =
      settle_cycles(CLK_HZ, SETTLE_US, SIM_FAST, FAST_CYCLES);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("prst_pin_ctrl: settling interval must be at least one cycle");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("prst_pin_ctrl: synchronizer needs at least one stage");
      end
      if (!SIM_FAST && CLK_HZ < 1000000) begin : g_bad_clk
         $error("prst_pin_ctrl: clock below 1 MHz not supported");
      end
   endgenerate

   logic pin_s;
   logic armed;
   logic accept;
   logic tmr_load, tmr_run, tmr_done;
   logic trig;

   assign trig = por_evt | dest_evt;

   prst_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (pin_s)
   );

   prst_fall_det u_fall (
      .clk  (clk),
      .rst_n(rst_n),
      .smp  (pin_s),
      .en   (armed),
      .pulse(seq_start)
   );

   prst_drive_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig),
      .ph0_end (ph0_end),
      .tmr_done(tmr_done),
      .oe      (pin_oe),
      .armed   (armed),
      .accept  (accept),
      .tmr_load(tmr_load),
      .tmr_run (tmr_run)
   );

   prst_settle_timer #(
      .LOAD_VAL(SETTLE_CYC)
   ) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tmr_load),
      .run  (tmr_run),
      .done (tmr_done)
   );

   prst_exit_gate #(
      .SELF_TEST(SELF_TEST)
   ) u_exit (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .pin_hi    (pin_s),
      .st_done   (st_done),
      .clr       (accept | seq_start),
      .exit_ready(exit_ready)
   );
endmodule

// File: rtl/prst_pin_ctrl_chk.sv
module prst_pin_ctrl_chk #(
   parameter int unsigned SETTLE_CYC = 16
) (
   input logic clk,
   input logic rst_n,
   input logic pin_oe,
   input logic por_evt,
   input logic dest_evt,
   input logic ph0_end,
   input logic exit_ready,
   input logic seq_start
);
   int unsigned gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 gap <= SETTLE_CYC;
      else if (pin_oe)            gap <= 0;
      else if (gap < SETTLE_CYC)  gap <= gap + 1;
   end

   // R1
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_start |=> !seq_start);

   // R2
   drive_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_oe) |-> $past(por_evt || dest_evt));

   // R3
   drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_oe) |-> $past(ph0_end));

   // R3
   drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe && !ph0_end) |=> pin_oe);

   // R4
   masked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pin_oe) |-> !seq_start);

   // R5
   settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gap < SETTLE_CYC) |-> !exit_ready);

   // R6
   exit_not_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe |-> !exit_ready);
endmodule

bind prst_pin_ctrl prst_pin_ctrl_chk #(
   .SETTLE_CYC(SETTLE_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pin_oe    (pin_oe),
   .por_evt   (por_evt),
   .dest_evt  (dest_evt),
   .ph0_end   (ph0_end),
   .exit_ready(exit_ready),
   .seq_start (seq_start)
);

// File: tb/prst_pin_ctrl_bench.sv
`timescale 1ns/1ps
module prst_pin_ctrl_bench;
   localparam int N = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_in = 1'b1;
   logic por_evt = 1'b0, dest_evt = 1'b0, ph0_end = 1'b0, st_done = 1'b0;
   logic oe_a, ex_a, ss_a;
   logic oe_b, ex_b, ss_b;

   always #2.5 clk = ~clk;

   prst_pin_ctrl #(.SIM_FAST(1'b1), .FAST_CYCLES(N), .SELF_TEST(1'b1)) u_prst_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_oe(oe_a),
      .por_evt(por_evt), .dest_evt(dest_evt), .ph0_end(ph0_end),
      .st_done(st_done), .exit_ready(ex_a), .seq_start(ss_a));

   prst_pin_ctrl #(.SIM_FAST(1'b1), .FAST_CYCLES(N), .SELF_TEST(1'b0)) u_prst_pin_ctrl_plain (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_oe(oe_b),
      .por_evt(por_evt), .dest_evt(dest_evt), .ph0_end(ph0_end),
      .st_done(st_done), .exit_ready(ex_b), .seq_start(ss_b));

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // behavioural reference: pipeline queue for the synchronizer, mode integer
   bit syncq[$];
   bit last_s;
   int mode;     // 0 armed, 1 driving, 2 settling
   int remain;
   bit st_seen;
   bit m_start;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         syncq = '{1'b1, 1'b1};
         last_s = 1'b1;
         mode = 0; remain = 0; st_seen = 0; m_start = 0;
      end else begin
         bit s_now, f, acc;
         s_now = syncq[1];
         f   = (mode == 0) && last_s && !s_now;
         acc = (mode != 1) && (por_evt || dest_evt);
         if (acc || m_start) st_seen = 0;
         else if (st_done) st_seen = 1;
         last_s = s_now;
         void'(syncq.pop_back());
         syncq.push_front(pin_in);
         if (mode == 0) begin
            if (acc) mode = 1;
         end else if (mode == 1) begin
            if (ph0_end) begin mode = 2; remain = N - 1; end
         end else begin
            if (acc) mode = 1;
            else if (remain == 0) mode = 0;
            else remain--;
         end
         m_start = f;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   int seq_cnt = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         bit e_oe, e_plain;
         e_oe = (mode == 1);
         e_plain = (mode == 0) && syncq[1];
         if (ss_a) seq_cnt++;
         chk(oe_a == e_oe, "R2 R3 R9 pin_oe", oe_a, e_oe);
         chk(oe_b == e_oe, "R2 R3 R9 pin_oe plain", oe_b, e_oe);
         chk(ss_a == m_start, "R1 R4 seq_start", ss_a, m_start);
         chk(ss_b == m_start, "R1 R4 seq_start plain", ss_b, m_start);
         chk(ex_b == e_plain, "R5 R6 exit_ready plain", ex_b, e_plain);
         chk(ex_a == (e_plain && st_seen), "R7 exit_ready selftest", ex_a, e_plain && st_seen);
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         finish_run();
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_por();  @(negedge clk); por_evt = 1;  @(negedge clk); por_evt = 0;  endtask
   task automatic pulse_dest(); @(negedge clk); dest_evt = 1; @(negedge clk); dest_evt = 0; endtask
   task automatic pulse_p0();   @(negedge clk); ph0_end = 1;  @(negedge clk); ph0_end = 0;  endtask
   task automatic pulse_st();   @(negedge clk); st_done = 1;  @(negedge clk); st_done = 0;  endtask

   initial begin
      step(4);
      rst_n = 1;
      step(1);
      // R8: reset state
      chk(oe_a == 0 && ss_a == 0, "R8 reset outputs", {oe_a, ss_a}, 0);
      chk(ex_b == 1, "R8 plain exit after reset", ex_b, 1);
      chk(ex_a == 0, "R8 selftest exit after reset", ex_a, 0);

      // R1: falling edge gives a single pulse
      seq_cnt = 0;
      @(negedge clk); pin_in = 0;
      step(4);
      @(negedge clk); pin_in = 1;
      step(4);
      chk(seq_cnt == 1, "R1 one start per edge", seq_cnt, 1);

      // R1: single-cycle glitch is still an edge
      seq_cnt = 0;
      @(negedge clk); pin_in = 0;
      @(negedge clk); pin_in = 1;
      step(5);
      chk(seq_cnt == 1, "R1 short low pulse", seq_cnt, 1);

      // R7: self-test strobe opens exit
      pulse_st();
      step(1);
      chk(ex_a == 1, "R7 exit after self test", ex_a, 1);

      // R2 R4 R9 R10: destructive drive with masked toggles and repeated triggers
      seq_cnt = 0;
      pulse_dest();
      chk(oe_a == 1, "R2 drive on destructive", oe_a, 1);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk); pin_in = ~pin_in;
      end
      @(negedge clk); pin_in = 1;
      pulse_por();
      step(3);
      chk(oe_a == 1, "R9 drive held through new trigger", oe_a, 1);
      pulse_p0();
      begin
         int g = 0;
         while (ex_b == 0 && g < 1000) begin g++; @(negedge clk); end
         chk(g == N, "R10 R5 settle length", g, N);
      end
      chk(seq_cnt == 0, "R4 no start while masked", seq_cnt, 0);
      chk(ex_a == 0, "R7 selftest cleared by drive", ex_a, 0);

      // R4: toggling during settle is ignored
      seq_cnt = 0;
      pulse_por();
      pulse_p0();
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); pin_in = ~pin_in;
      end
      @(negedge clk); pin_in = 1;
      step(N + 4);
      chk(seq_cnt == 0, "R4 no start during settle", seq_cnt, 0);

      // R5: trigger during settle restarts drive
      pulse_por();
      pulse_p0();
      step(N / 2);
      pulse_dest();
      chk(oe_a == 1, "R5 redrive from settle", oe_a, 1);
      step(N + 5);
      chk(oe_a == 1, "R3 drive waits for phase 0 end", oe_a, 1);
      pulse_p0();
      step(N + 3);
      chk(ex_b == 1, "R5 rearmed after restart", ex_b, 1);

      // R6: external device holds the line low
      seq_cnt = 0;
      pulse_dest();
      @(negedge clk); pin_in = 0;
      pulse_p0();
      step(N + 6);
      chk(ex_b == 0, "R6 exit blocked by external low", ex_b, 0);
      chk(seq_cnt == 0, "R6 no start from held low", seq_cnt, 0);
      @(negedge clk); pin_in = 1;
      step(3);
      chk(ex_b == 1, "R6 exit after release", ex_b, 1);

      // R7: clear wins over simultaneous self-test strobe
      @(negedge clk); st_done = 1; por_evt = 1;
      @(negedge clk); st_done = 0; por_evt = 0;
      pulse_p0();
      step(N + 3);
      chk(ex_a == 0, "R7 clear beats strobe", ex_a, 0);
      pulse_st();
      step(1);
      chk(ex_a == 1, "R7 strobe after drive", ex_a, 1);

      // random traffic compared against the reference every cycle
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         por_evt  = ($urandom_range(0, 59) == 0);
         dest_evt = ($urandom_range(0, 59) == 0);
         ph0_end  = ($urandom_range(0, 7) == 0);
         st_done  = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 5) == 0) pin_in = ~pin_in;
      end
      @(negedge clk);
      por_evt = 0; dest_evt = 0; ph0_end = 0; st_done = 0; pin_in = 1;
      step(4);
      finish_run();
   end
endmodule